// File: doc/BRIEF.md
# Core Idle Depth Sequencer

This block sits next to one processor core and steps it between the running state and three idle depths of growing power saving: halt (C1), clock-off with flushed caches (C3) and power-off with saved context (C6). A sleep request carries a depth code. The block always descends one step at a time. Each step adds one shutdown action to those already taken. Steps that depend on another agent wait for that agent's done handshake. These are the cache flush, the context save, the power rail coming back and the context restore.

A wake event reverses the order. A wake that arrives part way down stops the descent and undoes only the steps already completed. Leaving power-off follows a fixed sequence. The power switch closes, the block waits for power-good, the clocks restart and a context restore is requested, and the pipeline is released once the restore is done. The flush engine, the context store and the power switch sit outside the block and are reached only through request/done pairs.

Top module: `core_idle_seq`

## Requirements
- R1: After reset the pipeline runs (`stall`=0), both clock enables and `pwr_en` are 1, no request output is high and `level` is 0.
- R2: In the running state, a `sleep_req` with `sleep_depth`=1 sets `stall`=1, `clk_main_en`=0 and `level`=1 on the next clock edge. `clk_rest_en` stays 1, so caches can still answer snoops.
- R3: Depth codes are 1=C1, 2=C3 and 3=C6. Code 0 is invalid and is handled exactly like code 1.
- R4: For a C3 or C6 target, the cycle after C1 is reached, `flush_req` is raised and held. `clk_rest_en` drops, with `level`=2 and `flush_req` low, only on the edge that samples `flush_done`=1.
- R5: For a C6 target, the cycle after C3 is reached, `save_req` is raised and held. `pwr_en` drops, with `level`=3, only on the edge that samples `save_done`=1.
- R6: A wake in C6 sets `pwr_en`=1 on the next edge, with the clocks still off and the pipeline stalled. On the edge that samples `pwr_good`, both clocks restart and `restore_req` rises. On the edge that samples `restore_done`, `restore_req` drops, `stall` clears and `level` returns to 0.
- R7: A wake in C3 restores `clk_rest_en` and sets `level`=1 on the next edge. The edge after that releases the pipeline and sets `level`=0. A wake in C1 returns to `level`=0 in one edge.
- R8: A wake while `flush_req` or `save_req` is high drops that request on the next edge and unwinds through the shallower steps already taken, one per edge, ending at `level`=0. At most one of the three request outputs is high at any time.
- R9: A wake in the same cycle as a sleep request in the running state wins, so the core stays running. A sleep request outside the running state, a wake in the running state, and a done handshake outside the step that waits for it have no effect.
- R10: `level` reports the deepest state fully reached and still held: 0=C0, 1=C1, 2=C3, 3=C6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Request to enter an idle depth |
| sleep_depth | input | 2 | Target depth code carried with the request |
| wake_evt | input | 1 | Wake event |
| flush_done | input | 1 | Cache flush finished |
| save_done | input | 1 | Context save finished |
| pwr_good | input | 1 | Core rail is stable |
| restore_done | input | 1 | Context restore finished |
| stall | output | 1 | Pipeline stall |
| clk_main_en | output | 1 | Enable for most core clocks |
| clk_rest_en | output | 1 | Enable for the remaining core clocks |
| flush_req | output | 1 | Cache flush request |
| save_req | output | 1 | Context save request |
| restore_req | output | 1 | Context restore request |
| pwr_en | output | 1 | Power switch closed |
| level | output | 2 | Current idle depth |

## Verification
The bench builds the block with its default depth-code width of two bits. That width puts every code value within reach, including the invalid code 0. The stimulus walks full descents to each depth and the full wake from C6. It aborts descents in the middle of the flush and in the middle of the save. It also holds handshakes off for several cycles, so that each waiting step is seen holding its outputs, and it sends handshakes and requests in states where they must be ignored.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;

    localparam int DEPTH_W = 2;

    typedef enum logic [1:0] {
        LVL_C0 = 2'd0,
        LVL_C1 = 2'd1,
        LVL_C3 = 2'd2,
        LVL_C6 = 2'd3
    } depth_e;

    typedef enum logic [2:0] {
        S_RUN,
        S_HALT,
        S_FLUSH,
        S_DROWSE,
        S_SAVE,
        S_OFF,
        S_PWRUP,
        S_RESTORE
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        depth_e     tgt;
        logic       waking;
    } seq_reg_t;

    typedef struct packed {
        logic   stall;
        logic   clk_main_en;
        logic   clk_rest_en;
        logic   flush_req;
        logic   save_req;
        logic   restore_req;
        logic   pwr_en;
        depth_e level;
    } core_ctl_t;

endpackage

// File: rtl/idle_depth_decode.sv
module idle_depth_decode
    import idle_seq_pkg::*;
#(
    parameter int CODE_W = DEPTH_W
) (
    input  logic [CODE_W-1:0] code,
    output depth_e            depth
);
    localparam logic [CODE_W-1:0] CODE_C3 = CODE_W'(2);
    localparam logic [CODE_W-1:0] CODE_C6 = CODE_W'(3);

    always_comb begin
        if (code == CODE_C6)      depth = LVL_C6;
        else if (code == CODE_C3) depth = LVL_C3;
        else                      depth = LVL_C1;   // 1 and any invalid code
    end
endmodule

// File: rtl/idle_seq_fsm.sv
module idle_seq_fsm
    import idle_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  depth_e     tgt_in,
    input  logic       wake_evt,
    input  logic       flush_done,
    input  logic       save_done,
    input  logic       pwr_good,
    input  logic       restore_done,
    output seq_state_e state
);
    seq_reg_t seq_d, seq_q;
    logic     wake_any;

    always_comb begin
        seq_d    = seq_q;
        wake_any = wake_evt | seq_q.waking;
        case (seq_q.st)
            S_RUN: begin
                seq_d.waking = 1'b0;
                if (sleep_req && !wake_evt) begin
                    seq_d.st  = S_HALT;
                    seq_d.tgt = tgt_in;
                end
            end
            S_HALT: begin
                if (wake_any) begin
                    seq_d.st     = S_RUN;
                    seq_d.waking = 1'b0;
                end else if (seq_q.tgt != LVL_C1) begin
                    seq_d.st = S_FLUSH;
                end
            end
            S_FLUSH: begin
                if (wake_any) begin
                    seq_d.st     = S_HALT;
                    seq_d.waking = 1'b1;
                end else if (flush_done) begin
                    seq_d.st = S_DROWSE;
                end
            end
            S_DROWSE: begin
                if (wake_any) begin
                    seq_d.st     = S_HALT;
                    seq_d.waking = 1'b1;
                end else if (seq_q.tgt == LVL_C6) begin
                    seq_d.st = S_SAVE;
                end
            end
            S_SAVE: begin
                if (wake_any) begin
                    seq_d.st     = S_DROWSE;
                    seq_d.waking = 1'b1;
                end else if (save_done) begin
                    seq_d.st = S_OFF;
                end
            end
            S_OFF: begin
                if (wake_any) begin
                    seq_d.st     = S_PWRUP;
                    seq_d.waking = 1'b1;
                end
            end
            S_PWRUP: begin
                if (pwr_good) seq_d.st = S_RESTORE;
            end
            S_RESTORE: begin
                if (restore_done) begin
                    seq_d.st     = S_RUN;
                    seq_d.waking = 1'b0;
                end
            end
            default: seq_d.st = S_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: S_RUN, tgt: LVL_C1, waking: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state = seq_q.st;

    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != S_RUN && $past(seq_q.st) != S_RUN) |-> $stable(seq_q.tgt)) // R9
        else $error("target depth changed while idle");
endmodule

// File: rtl/idle_ctl_decode.sv
module idle_ctl_decode
    import idle_seq_pkg::*;
(
    input  seq_state_e state,
    output core_ctl_t  ctl
);
    always_comb begin
        ctl = '{stall: 1'b1, clk_main_en: 1'b0, clk_rest_en: 1'b0,
                flush_req: 1'b0, save_req: 1'b0, restore_req: 1'b0,
                pwr_en: 1'b1, level: LVL_C0};
        case (state)
            S_RUN: begin
                ctl.stall       = 1'b0;
                ctl.clk_main_en = 1'b1;
                ctl.clk_rest_en = 1'b1;
            end
            S_HALT: begin
                ctl.clk_rest_en = 1'b1;
                ctl.level       = LVL_C1;
            end
            S_FLUSH: begin
                ctl.clk_rest_en = 1'b1;
                ctl.flush_req   = 1'b1;
                ctl.level       = LVL_C1;
            end
            S_DROWSE: ctl.level = LVL_C3;
            S_SAVE: begin
                ctl.save_req = 1'b1;
                ctl.level    = LVL_C3;
            end
            S_OFF: begin
                ctl.pwr_en = 1'b0;
                ctl.level  = LVL_C6;
            end
            S_PWRUP: ctl.level = LVL_C6;
            S_RESTORE: begin
                ctl.clk_main_en = 1'b1;
                ctl.clk_rest_en = 1'b1;
                ctl.restore_req = 1'b1;
                ctl.level       = LVL_C6;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
    import idle_seq_pkg::*;
#(
    parameter int CODE_W = DEPTH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic [CODE_W-1:0] sleep_depth,
    input  logic              wake_evt,
    input  logic              flush_done,
    input  logic              save_done,
    input  logic              pwr_good,
    input  logic              restore_done,
    output logic              stall,
    output logic              clk_main_en,
    output logic              clk_rest_en,
    output logic              flush_req,
    output logic              save_req,
    output logic              restore_req,
    output logic              pwr_en,
    output logic [1:0]        level
);
    depth_e     tgt;
    seq_state_e state;
    core_ctl_t  ctl;

    idle_depth_decode #(.CODE_W(CODE_W)) u_dec (
        .code  (sleep_depth),
        .depth (tgt)
    );

    idle_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req    (sleep_req),
        .tgt_in       (tgt),
        .wake_evt     (wake_evt),
        .flush_done   (flush_done),
        .save_done    (save_done),
        .pwr_good     (pwr_good),
        .restore_done (restore_done),
        .state        (state)
    );

    idle_ctl_decode u_ctl (
        .state (state),
        .ctl   (ctl)
    );

    assign stall       = ctl.stall;
    assign clk_main_en = ctl.clk_main_en;
    assign clk_rest_en = ctl.clk_rest_en;
    assign flush_req   = ctl.flush_req;
    assign save_req    = ctl.save_req;
    assign restore_req = ctl.restore_req;
    assign pwr_en      = ctl.pwr_en;
    assign level       = ctl.level;

    AST_GATE_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_rest_en) |-> $past(flush_done)) // R4
        else $error("remaining clocks gated without flush done");
    AST_PWR_OFF_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> $past(save_done)) // R5
        else $error("power removed without save done");
    AST_OFF_FULLY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> (stall && !clk_main_en && !clk_rest_en)) // R5
        else $error("power off while clocks or pipeline active");
    AST_RESTORE_AFTER_PG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restore_req) |-> $past(pwr_good)) // R6
        else $error("restore requested before power good");
    AST_RELEASE_AFTER_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stall) && $past(restore_req)) |-> $past(restore_done)) // R6
        else $error("pipeline released before restore done");
    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_req, save_req, restore_req})) // R8
        else $error("more than one request active");
    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (level > $past(level)) |-> (level == $past(level) + 2'd1)) // R10
        else $error("level skipped a depth on entry");
endmodule

// File: tb/core_idle_seq_bench.sv
module core_idle_seq_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 0, wake_evt = 0, flush_done = 0, save_done = 0;
    logic pwr_good = 0, restore_done = 0;
    logic [1:0] sleep_depth = 0;
    logic stall, clk_main_en, clk_rest_en, flush_req, save_req, restore_req, pwr_en;
    logic [1:0] level;

    int checks = 0, fails = 0, cyc = 0;
    string cur_req = "R1";

    // reference model: depth reached, current activity, waking flag
    int m_lvl = 0, m_tgt = 1, m_act = 0;
    bit m_wk = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    core_idle_seq u_core_idle_seq (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_depth(sleep_depth),
        .wake_evt(wake_evt), .flush_done(flush_done), .save_done(save_done),
        .pwr_good(pwr_good), .restore_done(restore_done), .stall(stall),
        .clk_main_en(clk_main_en), .clk_rest_en(clk_rest_en), .flush_req(flush_req),
        .save_req(save_req), .restore_req(restore_req), .pwr_en(pwr_en), .level(level)
    );

    always @(posedge clk) begin
        bit wa;
        wa = wake_evt | m_wk;
        if (!rst_n) begin
            m_lvl = 0; m_tgt = 1; m_act = 0; m_wk = 0;
        end else if (m_act == 1) begin
            if (wa) begin m_act = 0; m_wk = 1; end
            else if (flush_done) begin m_act = 0; m_lvl = 2; end
        end else if (m_act == 2) begin
            if (wa) begin m_act = 0; m_wk = 1; end
            else if (save_done) begin m_act = 0; m_lvl = 3; end
        end else if (m_act == 3) begin
            if (pwr_good) m_act = 4;
        end else if (m_act == 4) begin
            if (restore_done) begin m_act = 0; m_lvl = 0; m_wk = 0; end
        end else if (m_lvl == 0) begin
            if (sleep_req && !wake_evt) begin
                m_lvl = 1;
                m_tgt = (sleep_depth == 0) ? 1 : int'(sleep_depth);
            end
        end else if (m_lvl == 1) begin
            if (wa) begin m_lvl = 0; m_wk = 0; end
            else if (m_tgt >= 2) m_act = 1;
        end else if (m_lvl == 2) begin
            if (wa) begin m_lvl = 1; m_wk = 1; end
            else if (m_tgt == 3) m_act = 2;
        end else begin
            if (wa) begin m_act = 3; m_wk = 1; end
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, "stall", stall, m_lvl != 0);
            chk(cur_req, "clk_main_en", clk_main_en, m_lvl == 0 || m_act == 4);
            chk(cur_req, "clk_rest_en", clk_rest_en, m_lvl <= 1 || m_act == 4);
            chk(cur_req, "pwr_en", pwr_en, m_lvl < 3 || m_act >= 3);
            chk(cur_req, "reqs", {flush_req, save_req, restore_req},
                {m_act == 1, m_act == 2, m_act == 4});
            chk(cur_req, "level", level, m_lvl);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sleep(int code);
        @(negedge clk); sleep_req = 1; sleep_depth = 2'(code);
        @(negedge clk); sleep_req = 0; sleep_depth = 0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake_evt = 1;
        @(negedge clk); wake_evt = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", "reset level", level, 0);
        chk("R1", "reset pwr_en", pwr_en, 1);
        chk("R1", "reset stall", stall, 0);

        cur_req = "R2";
        pulse_sleep(1);
        chk("R2", "C1 main clock", clk_main_en, 0);
        chk("R2", "C1 snoop clock", clk_rest_en, 1);
        idle(3);
        chk("R2", "no flush for C1", flush_req, 0);
        cur_req = "R7";
        pulse_wake();
        chk("R7", "C1 wake one edge", level, 0);
        idle(2);

        cur_req = "R3";
        pulse_sleep(0);
        idle(3);
        chk("R3", "invalid code acts as C1", level, 1);
        chk("R3", "invalid code no flush", flush_req, 0);
        pulse_wake();
        idle(2);

        cur_req = "R4";
        pulse_sleep(2);
        chk("R4", "flush raised", flush_req, 0);
        @(negedge clk);
        chk("R4", "flush raised", flush_req, 1);
        idle(3);
        chk("R4", "snoop clock held during flush", clk_rest_en, 1);
        flush_done = 1; @(negedge clk); flush_done = 0;
        chk("R4", "rest clock off after flush done", clk_rest_en, 0);
        cur_req = "R10";
        chk("R10", "C3 code", level, 2);
        idle(3);
        cur_req = "R7";
        pulse_wake();
        chk("R7", "C3 wake to C1", level, 1);
        @(negedge clk);
        chk("R7", "then to C0", level, 0);
        idle(2);

        cur_req = "R5";
        pulse_sleep(3);
        idle(1);
        flush_done = 1; @(negedge clk); flush_done = 0;
        idle(1);
        chk("R5", "save raised", save_req, 1);
        idle(3);
        chk("R5", "power held during save", pwr_en, 1);
        save_done = 1; @(negedge clk); save_done = 0;
        chk("R5", "power off", pwr_en, 0);
        chk("R10", "C6 code", level, 3);
        idle(3);
        cur_req = "R6";
        pulse_wake();
        chk("R6", "power back", pwr_en, 1);
        chk("R6", "clocks still off", clk_main_en, 0);
        idle(3);
        chk("R6", "no restore before pg", restore_req, 0);
        pwr_good = 1; @(negedge clk);
        chk("R6", "restore after pg", restore_req, 1);
        idle(2);
        restore_done = 1; @(negedge clk); restore_done = 0;
        chk("R6", "released", stall, 0);
        pwr_good = 0;
        idle(2);

        cur_req = "R8";
        pulse_sleep(3);
        idle(2);
        pulse_wake();
        chk("R8", "flush aborted", flush_req, 0);
        idle(3);
        chk("R8", "back to C0", level, 0);
        pulse_sleep(3);
        idle(1);
        flush_done = 1; @(negedge clk); flush_done = 0;
        idle(2);
        pulse_wake();
        chk("R8", "save aborted", save_req, 0);
        idle(4);
        chk("R8", "unwound to C0", level, 0);

        cur_req = "R9";
        @(negedge clk); sleep_req = 1; sleep_depth = 3; wake_evt = 1;
        @(negedge clk); sleep_req = 0; wake_evt = 0;
        chk("R9", "wake beats sleep", level, 0);
        pulse_wake();
        chk("R9", "wake in C0 ignored", level, 0);
        pulse_sleep(1);
        pulse_sleep(3);
        idle(2);
        chk("R9", "sleep in C1 ignored", flush_req, 0);
        flush_done = 1; save_done = 1; restore_done = 1; pwr_good = 1;
        @(negedge clk);
        flush_done = 0; save_done = 0; restore_done = 0; pwr_good = 0;
        idle(2);
        chk("R9", "stray handshakes ignored", level, 1);
        pulse_wake();
        idle(2);

        finish_run();
    end
endmodule